// File: doc/BRIEF.md
# Per-Timer Event Completion Status

This block watches a bank of event-done pulses shared by two event timers. Each event is enabled or not and is owned by exactly one timer. After a timer receives its trigger, the block records which of that timer's enabled events have reported done. When every enabled event owned by the timer has been seen, the block raises a completion flag for that timer alone.

Each flag stays set until software clears it by writing a one to it. The flag is presented twice, once in the main status view and once in the event status view, and both copies always hold the same value. A per-timer interrupt enable chooses whether a set flag contributes to the single interrupt request. Register access is handled outside this block; it receives clear strobes and enable bits as plain signals.

Top module: `evcmp_status`

## Requirements
- R1: After reset both completion flags, both mirrored bits and the interrupt request are 0.
- R2: Timer t's flag becomes 1 on the first rising edge at which, since t's last trigger, every enabled event owned by t has pulsed done, counting a done pulse sampled on that same edge.
- R3: Completion of one timer's events never sets the other timer's flag.
- R4: Bit t of the event status output equals bit t of the main status output in every cycle.
- R5: A set flag stays 1 until its clear strobe is sampled high, and is 0 from the edge after the clear.
- R6: When a flag's set condition and its clear strobe meet on the same edge, the flag ends up 1.
- R7: A trigger for timer t discards every done pulse that t's events produced before that trigger.
- R8: A timer with no enabled events that it owns never sets its flag.
- R9: The interrupt request equals the OR over t of (flag t AND interrupt enable t), with no register stage in between.
- R10: After a timer's flag has been set once, it cannot be set again until that timer is triggered again.
- R11: A done pulse that arrives in the same cycle as its owning timer's trigger is not counted.
- R12: Event e is owned by timer 0 when bit e of evt_owner_i is 0 and by timer 1 when it is 1; a timer counts only the events that it owns and that are enabled (evt_en_i bit e = 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_done_i | input | NUM_EVT | One-cycle done pulse per event |
| evt_en_i | input | NUM_EVT | Per-event enable |
| evt_owner_i | input | NUM_EVT*TMR_W | Owning timer index per event (one bit per event by default) |
| tmr_trig_i | input | NUM_TMR | One-cycle trigger pulse per timer |
| cmp_clr_i | input | NUM_TMR | Write-one-to-clear strobe per flag |
| cmp_irq_en_i | input | NUM_TMR | Interrupt enable per flag |
| cmp_stat_o | output | NUM_TMR | Completion flags, main status view |
| cmp_evstat_o | output | NUM_TMR | Completion flags, event status view |
| cmp_irq_o | output | 1 | Interrupt request |

## Verification
A flag reacts to the done pulse, trigger or clear sampled at a rising edge and shows its new value right after that edge, so each result is due one clock after the stimulus is presented; the interrupt request follows the flags and enables in the same cycle. The bench drives every input on the falling edge, waits for the next falling edge and then compares both flag views and the interrupt against a cycle model updated once per driven cycle. Directed sequences place the last done pulse, the trigger and the clear on chosen edges to reach same-cycle collisions, and random cycles mix all inputs afterwards.

// File: rtl/evcmp_pkg.sv
package evcmp_pkg;

    typedef struct packed {
        logic armed;
        logic flag;
    } tmr_state_t;

endpackage

// File: rtl/evcmp_seen.sv
module evcmp_seen #(
    parameter int NUM_EVT = 16,
    parameter int NUM_TMR = 2,
    parameter int TMR_W   = 1
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [NUM_EVT-1:0]       evt_done_i,
    input  logic [NUM_EVT*TMR_W-1:0] evt_owner_i,
    input  logic [NUM_TMR-1:0]       tmr_trig_i,
    output logic [NUM_EVT-1:0]       seen_o
);

    logic [NUM_EVT-1:0] seen_d, seen_q;

    always_comb begin
        seen_d = seen_q;
        for (int e = 0; e < NUM_EVT; e++) begin
            if (tmr_trig_i[evt_owner_i[e*TMR_W +: TMR_W]]) begin
                seen_d[e] = 1'b0;
            end else begin
                seen_d[e] = seen_q[e] | evt_done_i[e];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seen_q <= '0;
        end else begin
            seen_q <= seen_d;
        end
    end

    assign seen_o = seen_q;

endmodule

// File: rtl/evcmp_timer.sv
module evcmp_timer
    import evcmp_pkg::*;
#(
    parameter int NUM_EVT = 16,
    parameter int TMR_W   = 1,
    parameter int TMR_IDX = 0
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [NUM_EVT-1:0]       evt_done_i,
    input  logic [NUM_EVT-1:0]       evt_en_i,
    input  logic [NUM_EVT*TMR_W-1:0] evt_owner_i,
    input  logic [NUM_EVT-1:0]       seen_i,
    input  logic                     trig_i,
    input  logic                     clr_i,
    output logic                     flag_o
);

    localparam logic [TMR_W-1:0] MY_IDX = TMR_W'(TMR_IDX);

    tmr_state_t st_d, st_q;
    logic [NUM_EVT-1:0] member;
    logic [NUM_EVT-1:0] missing;
    logic               fire;

    always_comb begin
        for (int e = 0; e < NUM_EVT; e++) begin
            member[e] = evt_en_i[e] && (evt_owner_i[e*TMR_W +: TMR_W] == MY_IDX);
        end
        missing = member & ~(seen_i | evt_done_i);
        fire    = st_q.armed && !trig_i && (|member) && (missing == '0);

        st_d = st_q;
        if (trig_i) begin
            st_d.armed = 1'b1;
        end else if (fire) begin
            st_d.armed = 1'b0;
        end
        st_d.flag = fire | (st_q.flag & ~clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

endmodule

// File: rtl/evcmp_status.sv
module evcmp_status #(
    parameter int NUM_EVT = 16,
    parameter int NUM_TMR = 2,
    parameter int TMR_W   = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [NUM_EVT-1:0]       evt_done_i,
    input  logic [NUM_EVT-1:0]       evt_en_i,
    input  logic [NUM_EVT*TMR_W-1:0] evt_owner_i,
    input  logic [NUM_TMR-1:0]       tmr_trig_i,
    input  logic [NUM_TMR-1:0]       cmp_clr_i,
    input  logic [NUM_TMR-1:0]       cmp_irq_en_i,
    output logic [NUM_TMR-1:0]       cmp_stat_o,
    output logic [NUM_TMR-1:0]       cmp_evstat_o,
    output logic                     cmp_irq_o
);

    logic [NUM_EVT-1:0] seen;
    logic [NUM_TMR-1:0] flag;

    evcmp_seen #(
        .NUM_EVT (NUM_EVT),
        .NUM_TMR (NUM_TMR),
        .TMR_W   (TMR_W)
    ) seen_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .evt_done_i  (evt_done_i),
        .evt_owner_i (evt_owner_i),
        .tmr_trig_i  (tmr_trig_i),
        .seen_o      (seen)
    );

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        evcmp_timer #(
            .NUM_EVT (NUM_EVT),
            .TMR_W   (TMR_W),
            .TMR_IDX (t)
        ) tmr_i (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .evt_done_i  (evt_done_i),
            .evt_en_i    (evt_en_i),
            .evt_owner_i (evt_owner_i),
            .seen_i      (seen),
            .trig_i      (tmr_trig_i[t]),
            .clr_i       (cmp_clr_i[t]),
            .flag_o      (flag[t])
        );
    end

    assign cmp_stat_o   = flag;
    assign cmp_evstat_o = flag;
    assign cmp_irq_o    = |(flag & cmp_irq_en_i);

endmodule

// File: rtl/evcmp_status_chk.sv
module evcmp_status_chk #(
    parameter int NUM_EVT = 16,
    parameter int NUM_TMR = 2,
    parameter int TMR_W   = 1
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic [NUM_EVT-1:0]       evt_done_i,
    input logic [NUM_EVT-1:0]       evt_en_i,
    input logic [NUM_EVT*TMR_W-1:0] evt_owner_i,
    input logic [NUM_TMR-1:0]       tmr_trig_i,
    input logic [NUM_TMR-1:0]       cmp_clr_i,
    input logic [NUM_TMR-1:0]       cmp_irq_en_i,
    input logic [NUM_TMR-1:0]       cmp_stat_o,
    input logic [NUM_TMR-1:0]       cmp_evstat_o,
    input logic                     cmp_irq_o
);

    logic [NUM_TMR-1:0] has_evt;

    always_comb begin
        has_evt = '0;
        for (int t = 0; t < NUM_TMR; t++) begin
            for (int e = 0; e < NUM_EVT; e++) begin
                if (evt_en_i[e] && (evt_owner_i[e*TMR_W +: TMR_W] == TMR_W'(t))) begin
                    has_evt[t] = 1'b1;
                end
            end
        end
    end

    p_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmp_irq_o == |(cmp_stat_o & cmp_irq_en_i));

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_chk
        p_mirror_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cmp_evstat_o[t] == cmp_stat_o[t]);

        p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cmp_stat_o[t] && !cmp_clr_i[t]) |=> cmp_stat_o[t]);

        p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cmp_clr_i[t] && (evt_done_i == '0)) |=> !cmp_stat_o[t]);

        p_rise_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!cmp_stat_o[t] && (evt_done_i == '0)) |=> !cmp_stat_o[t]);

        p_no_evt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!cmp_stat_o[t] && !has_evt[t]) |=> !cmp_stat_o[t]);

        p_trig_no_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!cmp_stat_o[t] && tmr_trig_i[t]) |=> !cmp_stat_o[t]);
    end

endmodule

bind evcmp_status evcmp_status_chk #(
    .NUM_EVT (NUM_EVT),
    .NUM_TMR (NUM_TMR),
    .TMR_W   (TMR_W)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_done_i   (evt_done_i),
    .evt_en_i     (evt_en_i),
    .evt_owner_i  (evt_owner_i),
    .tmr_trig_i   (tmr_trig_i),
    .cmp_clr_i    (cmp_clr_i),
    .cmp_irq_en_i (cmp_irq_en_i),
    .cmp_stat_o   (cmp_stat_o),
    .cmp_evstat_o (cmp_evstat_o),
    .cmp_irq_o    (cmp_irq_o)
);

// File: tb/evcmp_status_tb_top.sv
module evcmp_status_tb_top;

    localparam int NE = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] done = '0, en = '0, own = '0;
    logic [1:0]    trig = '0, clr = '0, msk = '0;
    logic [1:0]    stat, evstat;
    logic          irq;

    logic [NE-1:0] m_seen = '0;
    logic [1:0]    m_armed = '0, m_flag = '0;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    evcmp_status #(.NUM_EVT(NE), .NUM_TMR(2)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .evt_done_i   (done),
        .evt_en_i     (en),
        .evt_owner_i  (own),
        .tmr_trig_i   (trig),
        .cmp_clr_i    (clr),
        .cmp_irq_en_i (msk),
        .cmp_stat_o   (stat),
        .cmp_evstat_o (evstat),
        .cmp_irq_o    (irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [NE-1:0] member(int t);
        logic [NE-1:0] m;
        for (int e = 0; e < NE; e++) m[e] = en[e] && (int'(own[e]) == t);
        return m;
    endfunction

    // one driven cycle: inputs on the falling edge, results on the next one
    task automatic step(logic [NE-1:0] d, logic [1:0] tg, logic [1:0] c, string tag);
        logic [NE-1:0] nseen;
        logic [1:0]    nflag, narm;
        done = d; trig = tg; clr = c;
        for (int t = 0; t < 2; t++) begin
            logic [NE-1:0] mb;
            logic fire;
            mb   = member(t);
            fire = m_armed[t] && !tg[t] && (mb != '0) && ((mb & ~(m_seen | d)) == '0);
            narm[t]  = tg[t] ? 1'b1 : (fire ? 1'b0 : m_armed[t]);
            nflag[t] = fire | (m_flag[t] & ~c[t]);
        end
        for (int e = 0; e < NE; e++) nseen[e] = tg[own[e]] ? 1'b0 : (m_seen[e] | d[e]);
        m_seen = nseen; m_armed = narm; m_flag = nflag;
        @(posedge clk);
        @(negedge clk);
        check({tag, " stat"}, 32'(stat), 32'(m_flag));
        check("R4 mirror", 32'(evstat), 32'(stat));
        check("R9 irq", 32'(irq), 32'(|(m_flag & msk)));
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 stat", 32'(stat), 0);
        check("R1 evstat", 32'(evstat), 0);
        check("R1 irq", 32'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // events 0,1 -> timer0, events 2,3 -> timer1 (R12 ownership bit)
        en = 16'h000F; own = 16'h000C; msk = 2'b11;
        step(16'h0003, 2'b11, 2'b00, "R11");
        check("R11 same-cycle done ignored", 32'(stat), 0);
        step(16'h0001, 2'b00, 2'b00, "R2");
        check("R2 partial", 32'(stat), 0);
        step(16'h0002, 2'b00, 2'b00, "R2");
        check("R3 only timer0 set", 32'(stat), 32'h1);
        check("R9 irq on", 32'(irq), 1);
        step(16'h0000, 2'b00, 2'b00, "R5");
        check("R5 sticky", 32'(stat), 32'h1);
        step(16'h0000, 2'b00, 2'b01, "R5");
        check("R5 cleared", 32'(stat), 0);
        step(16'h0003, 2'b00, 2'b00, "R10");
        check("R10 no reset without trigger", 32'(stat), 0);

        // set and clear on the same edge
        step(16'h0000, 2'b10, 2'b00, "R6");
        step(16'h0004, 2'b00, 2'b00, "R6");
        step(16'h0008, 2'b00, 2'b10, "R6");
        check("R6 set wins", 32'(stat), 32'h2);
        step(16'h0000, 2'b00, 2'b10, "R5");

        // stale done before trigger is dropped
        step(16'h0003, 2'b00, 2'b00, "R7");
        step(16'h0000, 2'b01, 2'b00, "R7");
        step(16'h0001, 2'b00, 2'b00, "R7");
        check("R7 stale done dropped", 32'(stat), 0);
        step(16'h0002, 2'b00, 2'b00, "R7");
        check("R7 complete", 32'(stat), 32'h1);
        step(16'h0000, 2'b00, 2'b01, "R5");

        // no enabled events
        en = '0;
        step(16'h0000, 2'b11, 2'b00, "R8");
        step(16'hFFFF, 2'b00, 2'b00, "R8");
        check("R8 never set", 32'(stat), 0);

        // ownership swap and disabled event
        en = 16'h0003; own = 16'h0001;
        step(16'h0000, 2'b11, 2'b00, "R12");
        step(16'h0022, 2'b00, 2'b00, "R12");
        check("R12 timer0 via event1", 32'(stat), 32'h1);
        step(16'h0001, 2'b00, 2'b00, "R12");
        check("R12 timer1 via event0", 32'(stat), 32'h3);
        msk = 2'b01;
        step(16'h0000, 2'b00, 2'b01, "R9");
        check("R9 masked", 32'(irq), 0);
        step(16'h0000, 2'b00, 2'b10, "R9");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [NE-1:0] d;
            logic [1:0] tg, c;
            if (i % 200 == 0) begin
                en  = NE'($urandom) & NE'($urandom);
                own = NE'($urandom);
                msk = 2'($urandom);
            end
            d  = NE'($urandom) & NE'($urandom);
            tg = {($urandom % 25) == 0, ($urandom % 25) == 0};
            c  = {($urandom % 15) == 0, ($urandom % 15) == 0};
            step(d, tg, c, "R2 random");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule